// File: doc/BRIEF.md
# Polled Console Register Window

This block is a slave on a simple CPU load/store bus that gives software a keyboard input channel and a display output channel through four word-aligned registers. Each channel has a status word, whose bit 0 is a ready flag, and a data word that carries one byte in bits 7:0. Software reaches these registers with ordinary loads and stores into a reserved high address window. Before each access it polls the ready flag. For input, the flag means a byte is waiting. For output, the flag means the data register can take a new byte.

On the device side the block talks to a keyboard source and a display sink through valid/ready handshakes. Each channel holds exactly one byte. A keyboard byte sits in the input holding register until the CPU loads it. A stored display byte is offered to the sink until the sink takes it.

Read data comes back on the cycle after the load, with a response strobe. Loads outside the window get no response and the read bus stays at zero.

Top module: `mmio_console`

## Requirements
- R1: The window starts at base 0xFFFF0000 and spans 256 bytes. A read whose address falls outside it produces no response: `bus_rvalid` stays 0 and `bus_rdata` stays 0.
- R2: A read inside the window returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the read is presented, and only in that cycle.
- R3: The word at offset 0x0 reads 1 in bit 0 when a keyboard byte is waiting and 0 otherwise. All its other bits read 0.
- R4: The word at offset 0x4 returns the waiting keyboard byte in bits 7:0, with bits 31:8 zero.
- R5: A read of offset 0x4 while a byte is waiting empties the input holder on that edge. After the read, offset 0x0 bit 0 reads 0 and `kbd_ready` is 1.
- R6: A keyboard byte is taken only while the holder is empty (`kbd_ready` = 1). While it is full, `kbd_ready` is 0 and the held byte is not replaced.
- R7: The word at offset 0x8 reads 1 in bit 0 while the display holder is free and 0 while it holds a byte. All its other bits read 0.
- R8: A write to offset 0xC while the display holder is free stores wdata bits 7:0. From the next cycle, `disp_valid` is 1 with that byte on `disp_data`, and offset 0x8 bit 0 reads 0.
- R9: When the display sink accepts (`disp_valid` and `disp_ready` both 1 at an edge), `disp_valid` drops and offset 0x8 bit 0 returns to 1.
- R10: A write to offset 0xC while the display holder is busy is ignored, and `disp_data` keeps the earlier byte.
- R11: Writes to offsets 0x0, 0x4 and 0x8 change no state.
- R12: Reads inside the window at any address other than the four aligned offsets return zero with `bus_rvalid` high.
- R13: After reset, the input holder is empty (`kbd_ready` 1), the display holder is free (`disp_valid` 0), and `bus_rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, zero when no response |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a hit |
| kbd_valid | input | 1 | Keyboard byte offered |
| kbd_data | input | 8 | Keyboard byte |
| kbd_ready | output | 1 | Input holder empty, byte will be taken |
| disp_valid | output | 1 | Display byte offered |
| disp_data | output | 8 | Display byte |
| disp_ready | input | 1 | Display sink takes the byte |

## Verification
The input path is tested three ways: a single keystroke read back, a second keystroke offered while the holder is still full, and a third after the holder empties. Together these separate a byte that is overwritten from one that is held, and a flag that clears on read from one that stays set. The output path is tested with a store whose upper bits carry garbage, a store made while the holder is busy, and a sink acceptance, to show that only the low byte is forwarded and that busy stores are dropped. A sweep of reads at unmapped, misaligned and out-of-window addresses separates an in-window zero response from no response at all.

// File: rtl/mmio_console_pkg.sv
package mmio_console_pkg;

  // Register offsets inside the window; software depends on these.
  localparam int unsigned OFF_IN_STAT  = 32'h0;
  localparam int unsigned OFF_IN_BYTE  = 32'h4;
  localparam int unsigned OFF_OUT_STAT = 32'h8;
  localparam int unsigned OFF_OUT_BYTE = 32'hC;

  typedef enum logic [2:0] {
    SEL_NONE     = 3'd0,
    SEL_IN_STAT  = 3'd1,
    SEL_IN_BYTE  = 3'd2,
    SEL_OUT_STAT = 3'd3,
    SEL_OUT_BYTE = 3'd4
  } reg_sel_e;

endpackage

// File: rtl/mmio_console_decode.sv
module mmio_console_decode
  import mmio_console_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output reg_sel_e          sel
);

  logic [WIN_W-1:0] offset;

  assign offset  = addr[WIN_W-1:0];
  assign win_hit = (addr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);

  always_comb begin
    sel = SEL_NONE;
    if (win_hit) begin
      if (offset == WIN_W'(OFF_IN_STAT))       sel = SEL_IN_STAT;
      else if (offset == WIN_W'(OFF_IN_BYTE))  sel = SEL_IN_BYTE;
      else if (offset == WIN_W'(OFF_OUT_STAT)) sel = SEL_OUT_STAT;
      else if (offset == WIN_W'(OFF_OUT_BYTE)) sel = SEL_OUT_BYTE;
    end
  end

endmodule

// File: rtl/mmio_console_inchan.sv
module mmio_console_inchan #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              src_ready,
  input  logic              take,
  output logic              full,
  output logic [BYTE_W-1:0] held
);

  logic              full_q;
  logic [BYTE_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      held_q <= '0;
    end else if (full_q) begin
      if (take) full_q <= 1'b0;
    end else if (src_valid) begin
      full_q <= 1'b1;
      held_q <= src_data;
    end
  end

  assign full      = full_q;
  assign held      = held_q;
  assign src_ready = !full_q;

  assert_reset_empty_R13: assert property (@(posedge clk)
    $past(rst) |-> !full_q);

  assert_clear_on_take_R5: assert property (@(posedge clk) disable iff (rst)
    (full_q && take) |=> !full_q);

  assert_hold_while_full_R6: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take) |=> (full_q && $stable(held_q)));

endmodule

// File: rtl/mmio_console_outchan.sv
module mmio_console_outchan #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              put,
  input  logic [BYTE_W-1:0] put_data,
  output logic              snk_valid,
  output logic [BYTE_W-1:0] snk_data,
  input  logic              snk_ready,
  output logic              free
);

  logic              free_q;
  logic [BYTE_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= 1'b1;
      byte_q <= '0;
    end else if (free_q) begin
      if (put) begin
        free_q <= 1'b0;
        byte_q <= put_data;
      end
    end else if (snk_ready) begin
      free_q <= 1'b1;
    end
  end

  assign free      = free_q;
  assign snk_valid = !free_q;
  assign snk_data  = byte_q;

  assert_reset_free_R13: assert property (@(posedge clk)
    $past(rst) |-> free_q);

  assert_store_offers_R8: assert property (@(posedge clk) disable iff (rst)
    (free_q && put) |=> (snk_valid && snk_data == $past(put_data)));

  assert_accept_frees_R9: assert property (@(posedge clk) disable iff (rst)
    (snk_valid && snk_ready) |=> free_q);

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (!free_q && !snk_ready) |=> (!free_q && $stable(byte_q)));

endmodule

// File: rtl/mmio_console.sv
module mmio_console
  import mmio_console_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WIN_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              kbd_valid,
  input  logic [BYTE_W-1:0] kbd_data,
  output logic              kbd_ready,
  output logic              disp_valid,
  output logic [BYTE_W-1:0] disp_data,
  input  logic              disp_ready
);

  localparam int unsigned PAD_W = DATA_W - BYTE_W;

  logic              win_hit;
  reg_sel_e          sel;
  logic              in_full;
  logic [BYTE_W-1:0] in_byte;
  logic              out_free;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BYTE_W];

  mmio_console_decode #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W),
    .BASE   (BASE)
  ) u_decode (
    .addr    (bus_addr),
    .win_hit (win_hit),
    .sel     (sel)
  );

  mmio_console_inchan #(.BYTE_W(BYTE_W)) u_inchan (
    .clk       (clk),
    .rst       (rst),
    .src_valid (kbd_valid),
    .src_data  (kbd_data),
    .src_ready (kbd_ready),
    .take      (bus_rd && sel == SEL_IN_BYTE),
    .full      (in_full),
    .held      (in_byte)
  );

  mmio_console_outchan #(.BYTE_W(BYTE_W)) u_outchan (
    .clk       (clk),
    .rst       (rst),
    .put       (bus_wr && sel == SEL_OUT_BYTE),
    .put_data  (bus_wdata[BYTE_W-1:0]),
    .snk_valid (disp_valid),
    .snk_data  (disp_data),
    .snk_ready (disp_ready),
    .free      (out_free)
  );

  assign rd_hit = bus_rd && win_hit;

  always_comb begin
    unique case (sel)
      SEL_IN_STAT:  rd_word = {{(DATA_W-1){1'b0}}, in_full};
      SEL_IN_BYTE:  rd_word = {{PAD_W{1'b0}}, in_byte};
      SEL_OUT_STAT: rd_word = {{(DATA_W-1){1'b0}}, out_free};
      default:      rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_hit;
      rdata_q  <= rd_hit ? rd_word : '0;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  assert_no_reply_outside_R1: assert property (@(posedge clk) disable iff (rst)
    (!win_hit || !bus_rd) |=> (!bus_rvalid && bus_rdata == '0));

  assert_reply_next_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win_hit) |=> bus_rvalid);

  assert_status_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_IN_STAT) |=> (bus_rdata[0] == $past(in_full)));

  assert_reset_rvalid_R13: assert property (@(posedge clk)
    $past(rst) |-> !bus_rvalid);

endmodule

// File: tb/test_mmio_console.sv
module test_mmio_console;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        kbd_valid = 1'b0;
  logic [7:0]  kbd_data = '0;
  logic        kbd_ready;
  logic        disp_valid;
  logic [7:0]  disp_data;
  logic        disp_ready = 1'b0;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  localparam logic [31:0] B = 32'hFFFF_0000;

  always #5 clk = ~clk;

  mmio_console i_mmio_console (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .kbd_ready(kbd_ready),
    .disp_valid(disp_valid), .disp_data(disp_data), .disp_ready(disp_ready)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: push expected response, present one-cycle read.
  task automatic cpu_read(logic [31:0] addr, logic [31:0] exp, string req);
    item_t it;
    it.exp = exp;
    it.req = req;
    @(negedge clk);
    sb.push_back(it);
    bus_addr = addr;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  // Read outside the window: nothing expected; monitor flags any reply.
  task automatic cpu_read_none(logic [31:0] addr);
    @(negedge clk);
    bus_addr = addr;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
  endtask

  task automatic cpu_write(logic [31:0] addr, logic [31:0] data);
    @(negedge clk);
    bus_addr  = addr;
    bus_wdata = data;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic kbd_send(logic [7:0] b);
    @(negedge clk);
    kbd_valid = 1'b1;
    kbd_data  = b;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  // Monitor: pop and compare each read response.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (sb.size() == 0) begin
        chk("R2 unexpected reply", bus_rdata, 32'hx);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      if (sb.size() != 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R2 missing replies actual=%0d expected=0", sb.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 kbd_ready", {31'b0, kbd_ready}, 32'h1);
    chk("R13 disp_valid", {31'b0, disp_valid}, 32'h0);
    chk("R13 rvalid", {31'b0, bus_rvalid}, 32'h0);
    cpu_read(B + 32'h0, 32'h0, "R13 R3 in status empty");
    cpu_read(B + 32'h8, 32'h1, "R13 R7 out status free");

    // R12 unmapped in-window, R1 outside window
    cpu_read(B + 32'h10, 32'h0, "R12 offset 0x10");
    cpu_read(B + 32'hFC, 32'h0, "R12 offset 0xFC");
    cpu_read(B + 32'h2,  32'h0, "R12 misaligned");
    cpu_read_none(32'hFFFE_0000);
    cpu_read_none(32'h0000_0004);
    cpu_read_none(B + 32'h100);

    // R3 R4 R5 single keystroke
    kbd_send(8'h41);
    chk("R6 kbd_ready low when full", {31'b0, kbd_ready}, 32'h0);
    cpu_read(B + 32'h0, 32'h1, "R3 byte waiting");
    cpu_read(B + 32'h4, 32'h41, "R4 input byte");
    chk("R5 kbd_ready after read", {31'b0, kbd_ready}, 32'h1);
    cpu_read(B + 32'h0, 32'h0, "R5 status cleared");

    // R6 offered while full is not taken
    kbd_send(8'h5A);
    @(negedge clk);
    kbd_valid = 1'b1;
    kbd_data  = 8'h77;
    repeat (3) @(negedge clk);
    chk("R6 kbd_ready held low", {31'b0, kbd_ready}, 32'h0);
    kbd_valid = 1'b0;
    cpu_read(B + 32'h4, 32'h5A, "R6 first byte kept");
    kbd_send(8'h77);
    cpu_read(B + 32'h4, 32'h77, "R6 next byte after empty");

    // R11 writes to status and input byte do nothing
    kbd_send(8'h33);
    cpu_write(B + 32'h0, 32'hFFFF_FFFF);
    cpu_write(B + 32'h4, 32'hFFFF_FFFF);
    cpu_write(B + 32'h8, 32'hFFFF_FFFF);
    chk("R11 disp_valid", {31'b0, disp_valid}, 32'h0);
    cpu_read(B + 32'h0, 32'h1, "R11 in status");
    cpu_read(B + 32'h8, 32'h1, "R11 out status");
    cpu_read(B + 32'h4, 32'h33, "R11 input byte");

    // R8 store with garbage upper bits
    cpu_write(B + 32'hC, 32'hABCD_0063);
    chk("R8 disp_valid", {31'b0, disp_valid}, 32'h1);
    chk("R8 disp_data", {24'b0, disp_data}, 32'h63);
    cpu_read(B + 32'h8, 32'h0, "R8 R7 out status busy");

    // R10 busy store dropped
    cpu_write(B + 32'hC, 32'h0000_0055);
    chk("R10 disp_data kept", {24'b0, disp_data}, 32'h63);
    chk("R10 disp_valid", {31'b0, disp_valid}, 32'h1);

    // R9 sink accepts
    @(negedge clk);
    disp_ready = 1'b1;
    @(negedge clk);
    disp_ready = 1'b0;
    chk("R9 disp_valid low", {31'b0, disp_valid}, 32'h0);
    cpu_read(B + 32'h8, 32'h1, "R9 out status free");

    // R8 second store after free
    cpu_write(B + 32'hC, 32'h0000_0021);
    chk("R8 second byte", {24'b0, disp_data}, 32'h21);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule